// File: doc/BRIEF.md
# PCI interrupt line router

The router sends four shared, level-sensitive PCI interrupt lines (A to D) to sixteen legacy interrupt-controller inputs. Each line has one routing byte in a small byte-wide configuration space. A routing byte below 16 names the controller input that the line drives. A value of 16 or more disconnects the line. Several lines may share one input, and that input is then the OR of their levels.

The block keeps a level bit for every pairing of line and input. The bit is set only while the line is high and is routed to that input. The vector is rebuilt on every clock edge from the live line levels and the routing that takes effect at that edge. A routing write therefore moves an asserted line to its new input, and releases the old input, in the same cycle that the write lands.

A query port reports whether a chosen line is routed, and to which input. A combinational helper gives the line that a device interrupt pin drives, based on the device's slot number. This is the usual rotation that spreads the pins of neighbouring slots over the four lines.

Top module: `pirq_router`

## Requirements
- R1: After reset, each of the four routing bytes reads 0x80 and `irq_o` is all zero.
- R2: The routing bytes for lines A, B, C and D sit at configuration addresses 0x60, 0x61, 0x62 and 0x63. A write with `cfg_we_i` high stores the full byte at the clock edge. `cfg_rdata_o` returns the stored byte in the same cycle that the address is presented.
- R3: A write to any other address changes no routing byte and no output. A read of any other address returns 0x00.
- R4: `irq_o[t]` is high exactly when at least one line is high and its routing byte equals t (0 to 15). Lines that share an input are ORed.
- R5: A line whose routing byte is 16 or more reaches no output, whatever its level.
- R6: A change on `line_lvl_i` shows on `irq_o` after the next rising clock edge, and not before it.
- R7: The edge that stores a routing byte also rebuilds all outputs from the current line levels. An asserted line leaves its old input and appears on the new one at that same edge.
- R8: For the line selected by `qry_line_i`, `qry_en_o` is 1 and `qry_tgt_o` equals the routing byte when the byte is below 16. Otherwise `qry_en_o` is 0 and `qry_tgt_o` is 31 (all ones), which marks an invalid target.
- R9: `sw_line_o` equals (`sw_pin_i` + `sw_slot_i` - 1) mod 4, where pin 0 to 3 means INTA to INTD.
- R10: Asserting `rst_ni` at any time clears every output at once and restores the routing bytes to 0x80, even while lines are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_we_i | input | 1 | Write strobe |
| cfg_rdata_o | output | 8 | Read data for `cfg_addr_i`, same cycle |
| line_lvl_i | input | 4 | Levels of lines A (bit 0) to D (bit 3) |
| irq_o | output | 16 | Interrupt-controller inputs 0 to 15 |
| qry_line_i | input | 2 | Line to query |
| qry_en_o | output | 1 | The queried line is routed |
| qry_tgt_o | output | 5 | Target of the queried line, 31 when not routed |
| sw_slot_i | input | 5 | Device slot number |
| sw_pin_i | input | 2 | Device interrupt pin, 0 = INTA |
| sw_line_o | output | 2 | Line that the pin drives |

## Verification
The routing function is driven from a table of routing sets and level patterns:
- all lines unrouted with all lines high, which separates disconnection from level masking;
- a one-to-one mapping, which exposes crossed or shifted target decoding;
- all four lines on one input with a single line high, and pairs of lines on a shared input, which separate OR merging from a last-writer-wins model;
- bytes of exactly 16 and 0xFF mixed with valid targets, which catch a disable compare that looks only at the low nibble.

Directed sequences then move a held line between inputs, probe outputs before and after the capturing edge, and pull reset while lines are high.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_byte_t;
  localparam route_byte_t ROUTE_RST = 8'h80;
  localparam route_byte_t ROUTE_BASE = 8'h60;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE = 32'h60,
  parameter pirq_pkg::route_byte_t RST_VAL = pirq_pkg::ROUTE_RST
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  pirq_pkg::route_byte_t cfg_wdata_i,
  input  logic cfg_we_i,
  output pirq_pkg::route_byte_t cfg_rdata_o,
  output pirq_pkg::route_byte_t [NUM_LINES-1:0] route_q_o,
  output pirq_pkg::route_byte_t [NUM_LINES-1:0] route_d_o
);
  logic [NUM_LINES-1:0] sel_w;

  for (genvar p = 0; p < NUM_LINES; p++) begin : g_reg
    assign sel_w[p] = (cfg_addr_i == ADDR_W'(BASE + p));
    assign route_d_o[p] = (cfg_we_i && sel_w[p]) ? cfg_wdata_i : route_q_o[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q_o[p] <= RST_VAL;
      else         route_q_o[p] <= route_d_o[p];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int p = 0; p < NUM_LINES; p++) begin
      if (sel_w[p]) cfg_rdata_o = route_q_o[p];
    end
  end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_TGTS = 16,
  localparam int unsigned TGT_W = $clog2(NUM_TGTS),
  localparam int unsigned VEC_W = NUM_LINES * NUM_TGTS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  pirq_pkg::route_byte_t [NUM_LINES-1:0] route_d_i,
  input  logic [NUM_LINES-1:0] line_lvl_i,
  output logic [VEC_W-1:0] lvl_q_o,
  output logic [NUM_TGTS-1:0] irq_o
);
  logic [VEC_W-1:0] lvl_d;

  // bit t*NUM_LINES + p : line p high and routed to target t
  for (genvar t = 0; t < NUM_TGTS; t++) begin : g_tgt
    for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
      assign lvl_d[t*NUM_LINES + p] = line_lvl_i[p]
          && (route_d_i[p][pirq_pkg::ROUTE_W-1:TGT_W] == '0)
          && (route_d_i[p][TGT_W-1:0] == TGT_W'(t));
    end
    assign irq_o[t] = |lvl_q_o[t*NUM_LINES +: NUM_LINES];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q_o <= '0;
    else         lvl_q_o <= lvl_d;
  end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [LINE_W-1:0] pin_i,
  output logic [LINE_W-1:0] line_o
);
  // power-of-two line count: modulo is truncation
  assign line_o = pin_i + slot_i[LINE_W-1:0] - LINE_W'(1);
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_TGTS = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned LINE_W = $clog2(NUM_LINES),
  localparam int unsigned TGT_W = $clog2(NUM_TGTS),
  localparam int unsigned VEC_W = NUM_LINES * NUM_TGTS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic cfg_we_i,
  output logic [7:0] cfg_rdata_o,
  input  logic [NUM_LINES-1:0] line_lvl_i,
  output logic [NUM_TGTS-1:0] irq_o,
  input  logic [LINE_W-1:0] qry_line_i,
  output logic qry_en_o,
  output logic [TGT_W:0] qry_tgt_o,
  input  logic [SLOT_W-1:0] sw_slot_i,
  input  logic [LINE_W-1:0] sw_pin_i,
  output logic [LINE_W-1:0] sw_line_o
);
  pirq_pkg::route_byte_t [NUM_LINES-1:0] route_q;
  pirq_pkg::route_byte_t [NUM_LINES-1:0] route_d;
  logic [VEC_W-1:0] lvl_q;
  pirq_pkg::route_byte_t qry_route;

  pirq_route_regs #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
    .BASE(int'(pirq_pkg::ROUTE_BASE)), .RST_VAL(pirq_pkg::ROUTE_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_we_i(cfg_we_i),
    .cfg_rdata_o(cfg_rdata_o), .route_q_o(route_q), .route_d_o(route_d)
  );

  pirq_level_map #(.NUM_LINES(NUM_LINES), .NUM_TGTS(NUM_TGTS)) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .route_d_i(route_d),
    .line_lvl_i(line_lvl_i), .lvl_q_o(lvl_q), .irq_o(irq_o)
  );

  pirq_swizzle #(.NUM_LINES(NUM_LINES), .SLOT_W(SLOT_W)) u_swz (
    .slot_i(sw_slot_i), .pin_i(sw_pin_i), .line_o(sw_line_o)
  );

  assign qry_route = route_q[qry_line_i];
  assign qry_en_o  = (qry_route[pirq_pkg::ROUTE_W-1:TGT_W] == '0);
  assign qry_tgt_o = qry_en_o ? {1'b0, qry_route[TGT_W-1:0]} : '1;
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_TGTS = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned TGT_W = $clog2(NUM_TGTS),
  localparam int unsigned VEC_W = NUM_LINES * NUM_TGTS
) (
  input logic clk_i,
  input logic rst_ni,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic cfg_we_i,
  input logic [NUM_LINES-1:0] line_lvl_i,
  input logic [NUM_TGTS-1:0] irq_o,
  input logic qry_en_o,
  input logic [TGT_W:0] qry_tgt_o,
  input pirq_pkg::route_byte_t [NUM_LINES-1:0] route_q,
  input logic [VEC_W-1:0] lvl_q
);
  logic [NUM_LINES-1:0] off_w;
  logic in_win;

  for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
    logic [NUM_TGTS-1:0] col;
    for (genvar t = 0; t < NUM_TGTS; t++) begin : g_col
      assign col[t] = lvl_q[t*NUM_LINES + p];
    end
    assign off_w[p] = (route_q[p][pirq_pkg::ROUTE_W-1:TGT_W] != '0);

    AST_LINE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col)); // R4
  end

  assign in_win = (cfg_addr_i >= ADDR_W'(pirq_pkg::ROUTE_BASE))
               && (cfg_addr_i <  ADDR_W'(int'(pirq_pkg::ROUTE_BASE) + NUM_LINES));

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&off_w) |-> (irq_o == '0)); // R5

  AST_IRQ_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ($past(line_lvl_i) != '0)); // R6

  AST_OTHER_ADDR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !in_win) |=> $stable(route_q)); // R3

  AST_QUERY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_en_o |-> (qry_tgt_o < (TGT_W+1)'(NUM_TGTS))); // R8
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_TGTS(NUM_TGTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_addr_i(cfg_addr_i), .cfg_we_i(cfg_we_i),
  .line_lvl_i(line_lvl_i), .irq_o(irq_o), .qry_en_o(qry_en_o),
  .qry_tgt_o(qry_tgt_o), .route_q(route_q), .lvl_q(lvl_q)
);

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_rdata;
  logic [3:0] line_lvl = '0;
  logic [15:0] irq;
  logic [1:0] qry_line = '0;
  logic qry_en;
  logic [4:0] qry_tgt;
  logic [4:0] sw_slot = '0;
  logic [1:0] sw_pin = '0;
  logic [1:0] sw_line;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pirq_router u_pirq_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_we_i(cfg_we),
    .cfg_rdata_o(cfg_rdata), .line_lvl_i(line_lvl), .irq_o(irq),
    .qry_line_i(qry_line), .qry_en_o(qry_en), .qry_tgt_o(qry_tgt),
    .sw_slot_i(sw_slot), .sw_pin_i(sw_pin), .sw_line_o(sw_line)
  );

  // {route A, B, C, D, levels, expected irq}
  localparam logic [51:0] VEC [8] = '{
    {8'h80, 8'h80, 8'h80, 8'h80, 4'hF, 16'h0000},
    {8'h00, 8'h01, 8'h02, 8'h03, 4'hF, 16'h000F},
    {8'h05, 8'h05, 8'h05, 8'h05, 4'h2, 16'h0020},
    {8'h0A, 8'h0B, 8'h0A, 8'h0F, 4'h5, 16'h0400},
    {8'h0A, 8'h0B, 8'h0A, 8'h0F, 4'h8, 16'h8000},
    {8'h03, 8'h10, 8'h0E, 8'h09, 4'hF, 16'h4208},
    {8'h0F, 8'h0F, 8'hFF, 8'h01, 4'h6, 16'h8000},
    {8'h07, 8'h03, 8'h07, 8'h03, 4'hA, 16'h0008}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    for (int p = 0; p < 4; p++) begin
      cfg_addr = 8'h60 + 8'(p); #0.5;
      check("R1 route", 32'(cfg_rdata), 32'h80);
    end
    qry_line = 2'd1; #0.5;
    check("R8 query unrouted en", 32'(qry_en), 32'h0);
    check("R8 query unrouted tgt", 32'(qry_tgt), 32'd31);
    rst_ni = 1'b1;

    // R4/R5/R2 vector walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      line_lvl = VEC[i][19:16];
      for (int p = 0; p < 4; p++)
        cfg_wr(8'h60 + 8'(p), VEC[i][51 - 8*p -: 8]);
      check($sformatf("R4 R5 vector %0d", i), 32'(irq), 32'(VEC[i][15:0]));
      for (int p = 0; p < 4; p++) begin
        cfg_addr = 8'h60 + 8'(p); #0.5;
        check("R2 readback", 32'(cfg_rdata), 32'(VEC[i][51 - 8*p -: 8]));
      end
    end

    // R8 query on routed line (C = 0x07, D = 0x03)
    qry_line = 2'd2; #0.5;
    check("R8 query en", 32'(qry_en), 32'h1);
    check("R8 query tgt", 32'(qry_tgt), 32'd7);

    // R3 writes outside window ignored
    line_lvl = 4'h2;
    cfg_wr(8'h64, 8'h00);
    cfg_wr(8'h5F, 8'h00);
    check("R3 irq kept", 32'(irq), 32'h0008);
    cfg_addr = 8'h61; #0.5;
    check("R3 route B kept", 32'(cfg_rdata), 32'h03);
    cfg_addr = 8'h64; #0.5;
    check("R3 other read", 32'(cfg_rdata), 32'h0);

    // R6 latency: not before the edge, after it
    @(negedge clk);
    line_lvl = 4'h1; #0.5;
    check("R6 before edge", 32'(irq), 32'h0008);
    @(negedge clk);
    check("R6 after edge", 32'(irq), 32'h0080);
    line_lvl = 4'h0;
    @(negedge clk);
    check("R6 release", 32'(irq), 32'h0);

    // R7 move held line A from 7 to 9
    line_lvl = 4'h1;
    @(negedge clk);
    check("R7 before move", 32'(irq), 32'h0080);
    cfg_wr(8'h60, 8'h09);
    check("R7 after move", 32'(irq), 32'h0200);
    cfg_wr(8'h60, 8'h10);
    check("R7 R5 cut at 16", 32'(irq), 32'h0);

    // R9 swizzle
    sw_slot = 5'd1; sw_pin = 2'd0; #0.5; check("R9 slot1 pin0", 32'(sw_line), 32'd0);
    sw_slot = 5'd2; sw_pin = 2'd3; #0.5; check("R9 slot2 pin3", 32'(sw_line), 32'd0);
    sw_slot = 5'd0; sw_pin = 2'd0; #0.5; check("R9 slot0 pin0", 32'(sw_line), 32'd3);
    sw_slot = 5'd5; sw_pin = 2'd2; #0.5; check("R9 slot5 pin2", 32'(sw_line), 32'd2);
    sw_slot = 5'd31; sw_pin = 2'd1; #0.5; check("R9 slot31 pin1", 32'(sw_line), 32'd3);

    // R10 reset while lines held high
    cfg_wr(8'h60, 8'h04);
    line_lvl = 4'hF;
    @(negedge clk);
    check("R10 pre", 32'(irq), 32'h0098);
    rst_ni = 1'b0; #0.5;
    check("R10 irq cleared", 32'(irq), 32'h0);
    cfg_addr = 8'h60; #0.5;
    check("R10 route restored", 32'(cfg_rdata), 32'h80);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule